// File: doc/BRIEF.md
# Dual-Convention Stack Engine

This block carries out byte and word push and pop operations on a 16-bit stack pointer, using a memory port that is one byte wide. A mode input picks the stack convention for each request. In next-free mode the pointer names the first unused byte below the stack. In last-used mode it names the byte that was pushed most recently. Words always occupy two adjacent bytes with the more significant byte at the lower address. The engine issues one byte access per cycle, updates the pointer when the operation completes, and reports popped data with a one-cycle done strobe.

Requests enter on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester keeps `req_valid` and the request fields steady until that edge. `req_ready` is low while an operation is in flight and while `sp_load` is high. The response side has no back-pressure: `done`, `fault` and `rsp_data` are presented once and are not held for the consumer. `sp_load` is a plain control input that presets the pointer while the engine is idle. The memory port answers within the same cycle: `mem_rdata` and `mem_err` belong to the address driven in that cycle.

Top module: `stack_engine`

## Requirements
- R1: In next-free mode (`mode`=0), a byte push writes `req_data[7:0]` at SP, and SP becomes SP-1.
- R2: In next-free mode, a word push writes `req_data[15:8]` at SP-1 in the first access cycle and `req_data[7:0]` at SP in the second, and SP becomes SP-2. The two accesses of any word use consecutive addresses, with the lower address first.
- R3: In next-free mode, a byte pop reads SP+1 and SP becomes SP+1. A word pop reads the high byte at SP+1 and then the low byte at SP+2, and SP becomes SP+2.
- R4: In last-used mode (`mode`=1), a push first lowers SP by 1 (byte) or 2 (word) and writes at the new SP. A word is written as the high byte at new SP, then the low byte at new SP+1.
- R5: In last-used mode, a byte pop reads SP and a word pop reads the high byte at SP and then the low byte at SP+1. SP then rises by 1 or 2.
- R6: The first memory access takes place in the cycle after the request is accepted, one access per cycle. `done` is high for exactly the one cycle after the last access. In that same cycle SP shows its new value, and for a pop `rsp_data` holds {high, low} (word) or {8'h00, byte} (byte pop).
- R7: All stack pointer and address arithmetic wraps modulo 2^16.
- R8: `req_ready` is low from the cycle after acceptance until `done` or `fault`. A request that is presented while `req_ready` is low causes no memory access and no change to SP.
- R9: If `mem_err` is high during an access, the operation stops. `fault` pulses for one cycle and `fault_addr` holds the failing address. `done` stays low and SP keeps its value from before the operation.
- R10: When the engine is idle, `sp_load` high sets SP to `sp_load_val` on the next edge. While `sp_load` is high, `req_ready` is low.
- R11: After reset, SP is 16'h0000, `req_ready` is high, and `done`, `fault` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | Convention: 0 next-free, 1 last-used; sampled on acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_pop | input | 1 | 1 pop, 0 push |
| req_word | input | 1 | 1 word, 0 byte |
| req_data | input | 16 | Push data (byte push uses bits 7:0) |
| sp_load | input | 1 | Preset the stack pointer |
| sp_load_val | input | 16 | Value for the preset |
| sp | output | 16 | Current stack pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, same cycle |
| mem_err | input | 1 | Access failed, same cycle |
| done | output | 1 | Operation completed (one cycle) |
| rsp_data | output | 16 | Data from the last pop |
| fault | output | 1 | Operation stopped on a memory error (one cycle) |
| fault_addr | output | 16 | Address of the last failing access |

## Verification
Random streams mix both conventions, both sizes and both directions from random pointer values. Comparing the addresses and write bytes against a bench model tells apart the post-decrement and pre-decrement conventions and their pop offsets. It also catches any byte-order swap within a word. Directed cases put the pointer at 16'h0000 and 16'hFFFF to expose wrap errors. They also present a request during a word operation, to show that busy requests are dropped rather than queued. An error injected on the second byte of a word pop separates an abort that keeps SP from one that commits a half update.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic {
    CONV_NEXT_FREE = 1'b0,
    CONV_LAST_USED = 1'b1
  } conv_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC0 = 2'd1,
    ST_ACC1 = 2'd2
  } seq_state_e;
endpackage

// File: rtl/stk_addr_plan.sv
module stk_addr_plan #(
  parameter int AW = stk_pkg::ADDR_W
) (
  input  logic          conv_i,
  input  logic          pop_i,
  input  logic          word_i,
  input  logic [AW-1:0] sp_i,
  output logic [AW-1:0] first_addr_o,
  output logic [AW-1:0] second_addr_o,
  output logic [AW-1:0] next_sp_o
);
  logic [AW-1:0] step;
  logic [AW-1:0] sp_dn, sp_up;

  assign step  = word_i ? AW'(2) : AW'(1);
  assign sp_dn = sp_i - step;
  assign sp_up = sp_i + step;

  always_comb begin
    first_addr_o  = sp_i;
    second_addr_o = sp_i;
    next_sp_o     = sp_i;
    if (conv_i == stk_pkg::CONV_NEXT_FREE) begin
      if (pop_i) begin
        first_addr_o  = sp_i + AW'(1);
        second_addr_o = sp_i + AW'(2);
        next_sp_o     = sp_up;
      end else begin
        first_addr_o  = word_i ? sp_i - AW'(1) : sp_i;
        second_addr_o = sp_i;
        next_sp_o     = sp_dn;
      end
    end else begin
      if (pop_i) begin
        first_addr_o  = sp_i;
        second_addr_o = sp_i + AW'(1);
        next_sp_o     = sp_up;
      end else begin
        first_addr_o  = sp_dn;
        second_addr_o = sp_i - AW'(1);
        next_sp_o     = sp_dn;
      end
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq #(
  parameter int AW = stk_pkg::ADDR_W,
  parameter int BW = stk_pkg::BYTE_W,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          pop_i,
  input  logic          word_i,
  input  logic [WW-1:0] data_i,
  input  logic [AW-1:0] first_addr_i,
  input  logic [AW-1:0] second_addr_i,
  input  logic [AW-1:0] next_sp_i,
  output logic          busy_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_wdata_o,
  input  logic [BW-1:0] mem_rdata_i,
  input  logic          mem_err_i,
  output logic          commit_o,
  output logic [AW-1:0] commit_sp_o,
  output logic          done_o,
  output logic [WW-1:0] rsp_data_o,
  output logic          fault_o,
  output logic [AW-1:0] fault_addr_o
);
  import stk_pkg::*;

  seq_state_e    state_q, state_d;
  logic          pop_q, word_q;
  logic [WW-1:0] data_q;
  logic [AW-1:0] a0_q, a1_q, nsp_q;
  logic [BW-1:0] hi_q;
  logic          last_acc;

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_en_o    = busy_o;
  assign mem_we_o    = busy_o && !pop_q;
  assign mem_addr_o  = (state_q == ST_ACC1) ? a1_q : a0_q;
  assign mem_wdata_o = (state_q == ST_ACC0 && word_q) ? data_q[WW-1:BW] : data_q[BW-1:0];

  assign last_acc    = (state_q == ST_ACC1) || (state_q == ST_ACC0 && !word_q);
  assign commit_o    = last_acc && !mem_err_i;
  assign commit_sp_o = nsp_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACC0;
      ST_ACC0: state_d = (mem_err_i || !word_q) ? ST_IDLE : ST_ACC1;
      ST_ACC1: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pop_q   <= 1'b0;
      word_q  <= 1'b0;
      data_q  <= '0;
      a0_q    <= '0;
      a1_q    <= '0;
      nsp_q   <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        pop_q  <= pop_i;
        word_q <= word_i;
        data_q <= data_i;
        a0_q   <= first_addr_i;
        a1_q   <= second_addr_i;
        nsp_q  <= next_sp_i;
      end
      if (state_q == ST_ACC0) hi_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
      rsp_data_o   <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      if (busy_o && mem_err_i) begin
        fault_o      <= 1'b1;
        fault_addr_o <= mem_addr_o;
      end else if (last_acc) begin
        done_o <= 1'b1;
        if (pop_q) begin
          rsp_data_o <= word_q ? {hi_q, mem_rdata_i} : {{BW{1'b0}}, mem_rdata_i};
        end
      end
    end
  end
endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int AW = stk_pkg::ADDR_W,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          upd_i,
  input  logic [AW-1:0] upd_val_i,
  output logic [AW-1:0] sp_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_o <= SP_RESET;
    else if (upd_i)  sp_o <= upd_val_i;
    else if (load_i) sp_o <= load_val_i;
  end
endmodule

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int AW = stk_pkg::ADDR_W,
  parameter int BW = stk_pkg::BYTE_W,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_pop,
  input  logic          req_word,
  input  logic [WW-1:0] req_data,
  input  logic          sp_load,
  input  logic [AW-1:0] sp_load_val,
  output logic [AW-1:0] sp,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          done,
  output logic [WW-1:0] rsp_data,
  output logic          fault,
  output logic [AW-1:0] fault_addr
);
  logic          busy, start, commit;
  logic [AW-1:0] a0, a1, nsp, commit_sp;

  assign req_ready = !busy && !sp_load;
  assign start     = req_valid && req_ready;

  stk_addr_plan #(.AW(AW)) u_plan (
    .conv_i        (mode),
    .pop_i         (req_pop),
    .word_i        (req_word),
    .sp_i          (sp),
    .first_addr_o  (a0),
    .second_addr_o (a1),
    .next_sp_o     (nsp)
  );

  stk_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .pop_i         (req_pop),
    .word_i        (req_word),
    .data_i        (req_data),
    .first_addr_i  (a0),
    .second_addr_i (a1),
    .next_sp_i     (nsp),
    .busy_o        (busy),
    .mem_en_o      (mem_en),
    .mem_we_o      (mem_we),
    .mem_addr_o    (mem_addr),
    .mem_wdata_o   (mem_wdata),
    .mem_rdata_i   (mem_rdata),
    .mem_err_i     (mem_err),
    .commit_o      (commit),
    .commit_sp_o   (commit_sp),
    .done_o        (done),
    .rsp_data_o    (rsp_data),
    .fault_o       (fault),
    .fault_addr_o  (fault_addr)
  );

  stk_sp_reg #(.AW(AW)) u_sp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (sp_load && !busy),
    .load_val_i (sp_load_val),
    .upd_i      (commit),
    .upd_val_i  (commit_sp),
    .sp_o       (sp)
  );
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int AW = stk_pkg::ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          sp_load,
  input logic [AW-1:0] sp,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          fault
);
  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  // R9
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R6
  done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_en));

  // R2
  word_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R9
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(sp_load)) |-> $stable(sp));
endmodule

bind stack_engine stk_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .sp_load   (sp_load),
  .sp        (sp),
  .mem_en    (mem_en),
  .mem_addr  (mem_addr),
  .done      (done),
  .fault     (fault)
);

// File: tb/sim_stack_engine.sv
module sim_stack_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, req_valid = 1'b0, req_pop = 1'b0, req_word = 1'b0;
  logic [15:0] req_data = '0;
  logic        sp_load = 1'b0;
  logic [15:0] sp_load_val = '0;
  logic        req_ready, mem_en, mem_we, mem_err, done, fault;
  logic [15:0] sp, mem_addr, rsp_data, fault_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  phys [0:255];
  logic [7:0]  refm [0:255];
  logic        err_en = 1'b0;
  logic [15:0] err_addr = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_engine u0 (.*);

  assign mem_rdata = phys[mem_addr[7:0]];
  assign mem_err   = err_en && (mem_addr == err_addr);

  always @(posedge clk)
    if (mem_en && mem_we && !mem_err) phys[mem_addr[7:0]] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] base_addr(input logic m, input logic p, input logic w, input logic [15:0] s);
    if (!m) return p ? s + 16'd1 : (w ? s - 16'd1 : s);
    else    return p ? s : (w ? s - 16'd2 : s - 16'd1);
  endfunction

  function automatic logic [15:0] after_sp(input logic p, input logic w, input logic [15:0] s);
    return p ? s + (w ? 16'd2 : 16'd1) : s - (w ? 16'd2 : 16'd1);
  endfunction

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    #1 chk(req_ready == 1'b0, "R10 ready low during load", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    sp_load = 1'b0;
    chk(sp == v, "R10 sp after load", {16'd0, sp}, {16'd0, v});
  endtask

  // ebad: expected fault on access index eidx (-1 none)
  task automatic run_op(input logic m, input logic p, input logic w, input logic [15:0] d,
                        input bit poke_busy, input int eidx, input string tag);
    logic [15:0] s0, b, expd;
    int nacc, nexp;
    bit got_done, got_fault;
    s0 = sp;
    b = base_addr(m, p, w, s0);
    nexp = w ? 2 : 1;
    if (eidx >= 0) nexp = eidx + 1;
    @(negedge clk);
    mode = m; req_pop = p; req_word = w; req_data = d; req_valid = 1'b1;
    #1 chk(req_ready == 1'b1, {tag, " ready idle"}, {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    nacc = 0; got_done = 0; got_fault = 0;
    for (int k = 0; k < 5; k++) begin
      if (poke_busy && k == 0) begin
        req_valid = 1'b1; req_pop = ~p;
        #1 chk(req_ready == 1'b0, "R8 ready low when busy", {31'd0, req_ready}, 32'd0);
      end
      if (poke_busy && k == 1) req_valid = 1'b0;
      if (done || fault) begin
        got_done = done; got_fault = fault;
        break;
      end
      if (mem_en) begin
        logic [15:0] ea;
        ea = b + 16'(nacc);
        chk(mem_addr == ea, {tag, " addr"}, {16'd0, mem_addr}, {16'd0, ea});
        chk(mem_we == !p, {tag, " we"}, {31'd0, mem_we}, {31'd0, !p});
        if (!p) begin
          logic [7:0] eb;
          eb = (w && nacc == 0) ? d[15:8] : d[7:0];
          chk(mem_wdata == eb, {tag, " wdata"}, {24'd0, mem_wdata}, {24'd0, eb});
          if (!(eidx == nacc)) refm[ea[7:0]] = eb;
        end
        nacc++;
      end
      @(negedge clk);
    end
    chk(nacc == nexp, {tag, " access count"}, nacc, nexp);
    if (eidx >= 0) begin
      logic [15:0] fa;
      fa = b + 16'(eidx);
      chk(got_fault && !got_done, "R9 fault not done", {30'd0, got_fault, got_done}, 32'd2);
      chk(fault_addr == fa, "R9 fault addr", {16'd0, fault_addr}, {16'd0, fa});
      chk(sp == s0, "R9 sp kept", {16'd0, sp}, {16'd0, s0});
    end else begin
      chk(got_done, {tag, " R6 done"}, {31'd0, got_done}, 32'd1);
      chk(sp == after_sp(p, w, s0), {tag, " sp"}, {16'd0, sp}, {16'd0, after_sp(p, w, s0)});
      if (p) begin
        expd = w ? {refm[b[7:0]], refm[8'(b[7:0] + 8'd1)]} : {8'h00, refm[b[7:0]]};
        chk(rsp_data == expd, {tag, " R6 rsp_data"}, {16'd0, rsp_data}, {16'd0, expd});
      end
      @(negedge clk);
      chk(!done && !mem_en, {tag, " R6 single done"}, {30'd0, done, mem_en}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) begin
      phys[i] = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(sp == 16'h0000, "R11 sp reset", {16'd0, sp}, 32'd0);
    chk(!done && !fault && !mem_en, "R11 outputs idle", {29'd0, done, fault, mem_en}, 32'd0);
    chk(req_ready, "R11 ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: each convention
    load_sp(16'h0080);
    run_op(1'b0, 1'b0, 1'b0, 16'h00A5, 0, -1, "R1 nf push byte");
    run_op(1'b0, 1'b0, 1'b1, 16'h1234, 0, -1, "R2 nf push word");
    run_op(1'b0, 1'b1, 1'b1, 16'h0000, 0, -1, "R3 nf pop word");
    run_op(1'b0, 1'b1, 1'b0, 16'h0000, 0, -1, "R3 nf pop byte");
    load_sp(16'h0040);
    run_op(1'b1, 1'b0, 1'b1, 16'hBEEF, 0, -1, "R4 lu push word");
    run_op(1'b1, 1'b0, 1'b0, 16'h005C, 0, -1, "R4 lu push byte");
    run_op(1'b1, 1'b1, 1'b0, 16'h0000, 0, -1, "R5 lu pop byte");
    run_op(1'b1, 1'b1, 1'b1, 16'h0000, 0, -1, "R5 lu pop word");

    // R7 wrap corners
    load_sp(16'h0000);
    run_op(1'b0, 1'b0, 1'b0, 16'h0011, 0, -1, "R7 nf push at 0000");
    run_op(1'b0, 1'b1, 1'b1, 16'h0000, 0, -1, "R7 nf pop word at FFFF");
    load_sp(16'hFFFF);
    run_op(1'b1, 1'b1, 1'b1, 16'h0000, 0, -1, "R7 lu pop word at FFFF");
    load_sp(16'h0000);
    run_op(1'b1, 1'b0, 1'b1, 16'hC3D4, 0, -1, "R7 lu push word at 0000");

    // R8 request during busy is dropped
    load_sp(16'h0090);
    run_op(1'b0, 1'b0, 1'b1, 16'h7788, 1, -1, "R8 busy word push");

    // R9 error on second byte of word pop
    load_sp(16'h00A0);
    err_en = 1'b1; err_addr = 16'h00A2;
    run_op(1'b0, 1'b1, 1'b1, 16'h0000, 0, 1, "R9 err pop");
    err_en = 1'b0;

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) load_sp(16'($urandom));
      else run_op(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 0, -1, "R1-5 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule